// File: doc/BRIEF.md
# Serial Word-Framed Message Checker

This block receives a message one bit at a time and checks its framing and its integrity. Every message opens with a start bit. A 5-bit length field follows, then that many 32-bit payload words, and finally one 32-bit check word. The check word is chosen so that every bit column, taken across all payload words and the check word together, holds an odd number of ones.

While the message arrives, the block rebuilds each payload word and hands it on as a one-cycle strobe. It also keeps a running column parity. When the message ends, it reports one of three outcomes with a single-cycle done pulse: good, length error, or parity error. An upstream bit recovery stage feeds it a bit with a qualifying strobe. Cycles without the strobe are simply skipped, so bits may arrive at any rate up to one per clock.

Top module: `msgchk_top`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, word_vld, msg_done, len_err and par_err are all 0.
- R2: While the receiver waits for a message, qualified 0 bits are ignored: they produce no output and do not start a message. A qualified 1 bit is taken as the start bit.
- R3: The 5 bits after the start bit form the length field, most significant bit first. Its value is the number of payload words that follow.
- R4: A length field of 0, or of 30 or 31, makes msg_done and len_err both 1 for exactly the one cycle after the fifth length bit. No payload word is reported, and the receiver waits for a new start bit.
- R5: Payload words are assembled most significant bit first. word_vld is 1 for exactly the one cycle after each word's 32nd bit, and word_data then holds that word.
- R6: A message with length field N (1 to 29) yields exactly N word_vld pulses. The 32 bits after the Nth word form the check word.
- R7: msg_done is 1 for the one cycle after the check word's last bit. In that cycle par_err is 1 exactly when the XOR of all payload words and the check word is not all ones. len_err is 0 in that cycle.
- R8: Cycles with bit_vld low have no effect, whatever value bit_in holds in those cycles.
- R9: After msg_done, the receiver waits for a start bit again, so messages can follow back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | Qualifies bit_in for this cycle |
| word_vld | output | 1 | One-cycle strobe: a payload word is complete |
| word_data | output | 32 | The completed payload word, valid with word_vld |
| msg_done | output | 1 | One-cycle strobe: the message has ended |
| len_err | output | 1 | The length field was out of range (with msg_done) |
| par_err | output | 1 | The column parity check failed (with msg_done) |

## Verification
The assertions assume that the strobes are spaced as real framing forces them to be. Two word strobes are therefore at least 32 qualified bits apart, and two done pulses are at least six bits apart. The assertions also take every reported word to follow a clock with bit_vld high. The stimulus keeps within these limits because it only ever drives whole, well-formed bit sequences. It adds leading zeros, idle gaps in which bit_in toggles but is not qualified, and out-of-range lengths, but it never truncates a message.

// File: rtl/msgchk_pkg.sv
// Shared types for the serial message checker.
// Assumes nothing beyond the receive-state encoding it defines.
package msgchk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // hunting for a start bit
        ST_LEN  = 2'd1,   // shifting in the length field
        ST_DATA = 2'd2,   // shifting in payload words
        ST_CHK  = 2'd3    // shifting in the check word
    } rx_state_e;

endpackage

// File: rtl/msgchk_shifter.sv
// Serial-to-parallel shifter, most significant bit first.
// It holds the last W-1 accepted bits. The word that would be complete
// if bit_in were accepted this cycle is shown combinationally on
// next_word, so the controller can capture a word on its final bit.
// Assumes W >= 2.
module msgchk_shifter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] next_word
);

    logic [W-2:0] hist_q;

    // Form the candidate word from the history and the incoming bit.
    always_comb begin
        next_word = {hist_q, bit_in};
    end

    // Shift accepted bits into the history register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (shift_en) begin
            hist_q <= next_word[W-2:0];
        end
    end

endmodule

// File: rtl/msgchk_parity.sv
// Column parity accumulator: a running XOR over the payload words.
// It is cleared while no message is in progress.
// Assumes clr and acc_en are not both requested for one word.
module msgchk_parity #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         acc_en,
    input  logic [W-1:0] word_in,
    output logic [W-1:0] acc
);

    // Clear the accumulator, or fold in one more word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clr) begin
            acc <= '0;
        end else if (acc_en) begin
            acc <= acc ^ word_in;
        end
    end

endmodule

// File: rtl/msgchk_ctrl.sv
// Receive sequencer. It follows the framing (start bit, length field,
// payload words, check word), counts bits and words, and registers all
// status strobes so that each one appears in the cycle after the bit
// that caused it.
// Assumes LEN_W <= WORD_W and that MAX_WORDS fits in LEN_W bits.
module msgchk_ctrl
    import msgchk_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int LEN_W     = 5,
    parameter int MAX_WORDS = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              bit_vld,
    input  logic [WORD_W-1:0] next_word,
    input  logic [WORD_W-1:0] par_acc,
    output logic              shift_en,
    output logic              par_clr,
    output logic              par_acc_en,
    output logic              word_vld,
    output logic [WORD_W-1:0] word_data,
    output logic              msg_done,
    output logic              len_err,
    output logic              par_err
);

    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_WORD_BIT = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] LAST_LEN_BIT  = CNT_W'(LEN_W - 1);
    localparam logic [LEN_W-1:0] LEN_MAX       = LEN_W'(MAX_WORDS);
    localparam logic [WORD_W-1:0] ALL_ONES     = '1;

    rx_state_e        state_q;
    logic [CNT_W-1:0] bit_cnt_q;
    logic [LEN_W-1:0] word_cnt_q;
    logic [LEN_W-1:0] len_q;

    logic [LEN_W-1:0] len_next;
    logic             len_ok;
    logic             word_end;
    logic             len_end;
    logic             last_payload;

    // Decode the field boundaries and the length check for this cycle.
    always_comb begin
        len_next     = next_word[LEN_W-1:0];
        len_ok       = (len_next != '0) && (len_next <= LEN_MAX);
        word_end     = (bit_cnt_q == LAST_WORD_BIT);
        len_end      = (bit_cnt_q == LAST_LEN_BIT);
        last_payload = (word_cnt_q == (len_q - LEN_W'(1)));
    end

    // Drive the shifter and the parity accumulator.
    always_comb begin
        shift_en   = bit_vld && (state_q != ST_IDLE);
        par_clr    = (state_q == ST_IDLE);
        par_acc_en = bit_vld && (state_q == ST_DATA) && word_end;
    end

    // Advance the framing state and issue the one-cycle status strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            bit_cnt_q  <= '0;
            word_cnt_q <= '0;
            len_q      <= '0;
            word_vld   <= 1'b0;
            word_data  <= '0;
            msg_done   <= 1'b0;
            len_err    <= 1'b0;
            par_err    <= 1'b0;
        end else begin
            word_vld <= 1'b0;
            msg_done <= 1'b0;
            len_err  <= 1'b0;
            par_err  <= 1'b0;
            if (bit_vld) begin
                case (state_q)
                    ST_IDLE: begin
                        if (bit_in) begin
                            state_q   <= ST_LEN;
                            bit_cnt_q <= '0;
                        end
                    end
                    ST_LEN: begin
                        if (len_end) begin
                            bit_cnt_q <= '0;
                            if (len_ok) begin
                                len_q      <= len_next;
                                word_cnt_q <= '0;
                                state_q    <= ST_DATA;
                            end else begin
                                msg_done <= 1'b1;
                                len_err  <= 1'b1;
                                state_q  <= ST_IDLE;
                            end
                        end else begin
                            bit_cnt_q <= bit_cnt_q + CNT_W'(1);
                        end
                    end
                    ST_DATA: begin
                        if (word_end) begin
                            bit_cnt_q <= '0;
                            word_vld  <= 1'b1;
                            word_data <= next_word;
                            if (last_payload) begin
                                state_q <= ST_CHK;
                            end else begin
                                word_cnt_q <= word_cnt_q + LEN_W'(1);
                            end
                        end else begin
                            bit_cnt_q <= bit_cnt_q + CNT_W'(1);
                        end
                    end
                    ST_CHK: begin
                        if (word_end) begin
                            bit_cnt_q <= '0;
                            msg_done  <= 1'b1;
                            par_err   <= ((par_acc ^ next_word) != ALL_ONES);
                            state_q   <= ST_IDLE;
                        end else begin
                            bit_cnt_q <= bit_cnt_q + CNT_W'(1);
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/msgchk_top.sv
// Serial message checker top. It joins the bit shifter, the column
// parity accumulator and the framing sequencer.
// Assumes bits arrive already recovered and qualified by bit_vld.
module msgchk_top #(
    parameter int WORD_W    = 32,
    parameter int LEN_W     = 5,
    parameter int MAX_WORDS = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              bit_vld,
    output logic              word_vld,
    output logic [WORD_W-1:0] word_data,
    output logic              msg_done,
    output logic              len_err,
    output logic              par_err
);

    logic [WORD_W-1:0] next_word;
    logic [WORD_W-1:0] par_acc;
    logic              shift_en;
    logic              par_clr;
    logic              par_acc_en;

    msgchk_shifter #(.W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .bit_in    (bit_in),
        .next_word (next_word)
    );

    msgchk_parity #(.W(WORD_W)) u_par (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (par_clr),
        .acc_en  (par_acc_en),
        .word_in (next_word),
        .acc     (par_acc)
    );

    msgchk_ctrl #(
        .WORD_W    (WORD_W),
        .LEN_W     (LEN_W),
        .MAX_WORDS (MAX_WORDS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_in     (bit_in),
        .bit_vld    (bit_vld),
        .next_word  (next_word),
        .par_acc    (par_acc),
        .shift_en   (shift_en),
        .par_clr    (par_clr),
        .par_acc_en (par_acc_en),
        .word_vld   (word_vld),
        .word_data  (word_data),
        .msg_done   (msg_done),
        .len_err    (len_err),
        .par_err    (par_err)
    );

endmodule

// File: rtl/msgchk_sva.sv
// Property checker for msgchk_top, attached to it with bind.
// Observes only the top-level ports. A small counter tracks the payload
// words reported in the current message.
module msgchk_sva #(
    parameter int MAX_WORDS = 29
) (
    input logic clk,
    input logic rst_n,
    input logic bit_vld,
    input logic word_vld,
    input logic msg_done,
    input logic len_err,
    input logic par_err
);

    logic [7:0] words_seen;

    // Count payload words since the last message end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words_seen <= '0;
        end else if (msg_done) begin
            words_seen <= '0;
        end else if (word_vld) begin
            words_seen <= words_seen + 8'd1;
        end
    end

    a_r4_len_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> (msg_done && !word_vld && !par_err));

    a_r7_par_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> (msg_done && !len_err));

    a_r5_word_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld);

    a_r7_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        msg_done |=> !msg_done);

    a_r8_word_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_vld) |-> $past(bit_vld));

    a_r6_done_without_word: assert property (@(posedge clk) disable iff (!rst_n)
        msg_done |-> !word_vld);

    a_r6_word_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> (32'(words_seen) < MAX_WORDS));

    a_r1_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({word_vld, msg_done}));

endmodule

bind msgchk_top msgchk_sva #(.MAX_WORDS(MAX_WORDS)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_vld  (bit_vld),
    .word_vld (word_vld),
    .msg_done (msg_done),
    .len_err  (len_err),
    .par_err  (par_err)
);

// File: tb/msgchk_top_tb.sv
module msgchk_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_in = 1'b0;
    logic        bit_vld = 1'b0;
    logic        word_vld;
    logic [31:0] word_data;
    logic        msg_done;
    logic        len_err;
    logic        par_err;

    msgchk_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_in    (bit_in),
        .bit_vld   (bit_vld),
        .word_vld  (word_vld),
        .word_data (word_data),
        .msg_done  (msg_done),
        .len_err   (len_err),
        .par_err   (par_err)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc++;

    int checks = 0;
    int errors = 0;
    int seen_words = 0;
    bit model_on = 1'b0;

    typedef struct {
        int          at;
        logic        wv;
        logic [31:0] wd;
        logic        dn;
        logic        le;
        logic        pe;
    } ev_t;

    ev_t evq[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // Reference model: expected outputs per cycle, taken from a queue of events.
    always @(negedge clk) begin
        if (model_on) begin
            ev_t e;
            e = '{at: cyc, wv: 1'b0, wd: 32'h0, dn: 1'b0, le: 1'b0, pe: 1'b0};
            if (evq.size() > 0 && evq[0].at < cyc) begin
                chk(1'b0, "R6", "expected event never seen", 32'(cyc), 32'(evq[0].at));
                void'(evq.pop_front());
            end
            if (evq.size() > 0 && evq[0].at == cyc) e = evq.pop_front();
            chk(word_vld == e.wv, "R5", "word_vld", 32'(word_vld), 32'(e.wv));
            if (e.wv && word_vld) chk(word_data == e.wd, "R5", "word_data", word_data, e.wd);
            chk(msg_done == e.dn, "R7", "msg_done", 32'(msg_done), 32'(e.dn));
            chk(len_err == e.le, "R4", "len_err", 32'(len_err), 32'(e.le));
            chk(par_err == e.pe, "R7", "par_err", 32'(par_err), 32'(e.pe));
            if (word_vld) seen_words++;
        end
    end

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog actual=%0d expected<=150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            bit_vld = 1'b0;
            bit_in  = 1'b0;
        end
    endtask

    // Unqualified gap cycles keep bit_in at 1, which must be ignored (R8).
    task automatic send_bit(input logic b, input int gap, output int at);
        repeat (gap) begin
            @(negedge clk);
            bit_vld = 1'b0;
            bit_in  = 1'b1;
        end
        @(negedge clk);
        bit_vld = 1'b1;
        bit_in  = b;
        at = cyc + 1;
    endtask

    function automatic logic [31:0] word_val(input int k, input int n);
        return (32'hA5C3_0F11 ^ (32'(k) * 32'h0101_0107)) + 32'(n * 977);
    endfunction

    task automatic send_msg(input logic [4:0] len, input int gap, input bit corrupt);
        int at;
        logic [31:0] acc;
        logic [31:0] w;
        ev_t e;
        acc = 32'h0;
        seen_words = 0;
        send_bit(1'b1, gap, at);
        for (int i = 4; i >= 0; i--) send_bit(len[i], gap, at);
        if (len == 5'd0 || len > 5'd29) begin
            e = '{at: at, wv: 1'b0, wd: 32'h0, dn: 1'b1, le: 1'b1, pe: 1'b0};
            evq.push_back(e);
            idle(3);
            return;
        end
        for (int k = 0; k < int'(len); k++) begin
            w = word_val(k, int'(len));
            for (int b = 31; b >= 0; b--) send_bit(w[b], gap, at);
            e = '{at: at, wv: 1'b1, wd: w, dn: 1'b0, le: 1'b0, pe: 1'b0};
            evq.push_back(e);
            acc ^= w;
        end
        w = ~acc ^ (corrupt ? 32'h0001_0000 : 32'h0);
        for (int b = 31; b >= 0; b--) send_bit(w[b], gap, at);
        e = '{at: at, wv: 1'b0, wd: 32'h0, dn: 1'b1, le: 1'b0, pe: corrupt};
        evq.push_back(e);
        idle(3);
    endtask

    task automatic run_msg(input logic [4:0] len, input int gap, input bit corrupt);
        int exp_words;
        send_msg(len, gap, corrupt);
        @(posedge clk);
        exp_words = (len == 5'd0 || len > 5'd29) ? 0 : int'(len);
        // R3 and R6: the length field sets the number of word strobes
        chk(seen_words == exp_words, "R6", "word count", 32'(seen_words), 32'(exp_words));
        chk(evq.size() == 0, "R9", "pending events", 32'(evq.size()), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs are quiet while reset is low
        chk(!word_vld && !msg_done && !len_err && !par_err, "R1", "outputs in reset",
            {28'h0, word_vld, msg_done, len_err, par_err}, 32'h0);
        rst_n = 1'b1;
        model_on = 1'b1;
        // R2: qualified zeros while idle produce nothing and start nothing
        repeat (6) begin
            @(negedge clk);
            bit_vld = 1'b1;
            bit_in  = 1'b0;
        end
        idle(2);
        run_msg(5'd1, 0, 1'b0);      // R3, R5, R7: shortest good message
        run_msg(5'd3, 2, 1'b0);      // R8: gaps between bits
        run_msg(5'd29, 0, 1'b0);     // R6: largest length
        run_msg(5'd2, 1, 1'b1);      // R7: parity failure
        run_msg(5'd0, 0, 1'b0);      // R4: zero length
        run_msg(5'd30, 0, 1'b0);     // R4: just above range
        run_msg(5'd31, 1, 1'b0);     // R4: top code
        run_msg(5'd5, 0, 1'b0);      // R9: recovers after errors
        run_msg(5'd4, 0, 1'b1);      // R7: parity failure, back to back
        run_msg(5'd1, 0, 1'b0);      // R9: back to back message
        idle(4);
        model_on = 1'b0;
        summary();
        $finish;
    end

endmodule